// File: doc/BRIEF.md
# Flash Block Write-Protection Lock Controller

This block holds the write-protection state of every erase block in a flash array with a parameterised block count. Each block is in one of three one-hot states: lock-tight, locked or unlocked. A cold reset puts every block in the locked state. Software sets a first and a last block address and then issues a command. The command can unlock a range, lock a range, set lock-tight on a range, or unlock the whole array.

An accepted command runs as a sweep. The sweep visits one block per clock. Busy is high while it runs, and a one-cycle done strobe marks its end. The sweep stops at the first lock-tight block when unlocking or locking. When setting lock-tight, it passes over unlocked blocks and leaves them as they are. A status register holds the state most recently written to any block. A combinational lookup port gives the state of any block to a program or erase engine, which uses it to decide whether an operation is allowed.

Top module: `wp_lock_ctrl`

## Requirements
- R1: After reset every block reads locked (3'b010), the status register reads 3'b010, busy is low, and both address registers read 0.
- R2: The lookup port returns the state of the addressed block as one-hot: 3'b001 lock-tight, 3'b010 locked, 3'b100 unlocked. An index at or above the block count returns 3'b000.
- R3: A write to the first-block register loads both the first and the last register with the data ANDed with (block count - 1). A write to the last-block register changes only the last register, with the same masking.
- R4: Command 8'h23 unlocks blocks from first to last inclusive, in ascending order. The sweep ends without change at the first lock-tight block it meets.
- R5: Command 8'h2A locks blocks from first to last inclusive, in ascending order. The sweep ends without change at the first lock-tight block it meets.
- R6: Command 8'h27 unlocks blocks from 0 up to the last block of the array. The sweep ends at the first lock-tight block it meets.
- R7: Command 8'h2C sets lock-tight on every block in the first..last range that is not unlocked. Unlocked blocks keep their state and the sweep continues past them.
- R8: Every block write also loads the written state into the status register. A sweep that writes nothing leaves the status register unchanged.
- R9: Busy rises on the clock that accepts a command. It stays high for one clock per block visited plus one closing clock. Done pulses for exactly one clock as busy falls. A range whose first address is above its last address completes after one busy clock and changes nothing.
- R10: A command offered while busy is high is ignored. So is a command code outside the four above, which does not raise busy.
- R11: The error strobe pulses together with done only when a sweep reaches a block index at or above the block count. Because the address registers are masked, range commands always complete with the error strobe low.
- R12: A lock-tight block stays lock-tight until the next reset, whatever command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous cold reset |
| first_wr_i | input | 1 | Write strobe for the first-block register (also loads the last-block register) |
| last_wr_i | input | 1 | Write strobe for the last-block register |
| wr_data_i | input | DATA_W | Register write data |
| cmd_valid_i | input | 1 | Command offer strobe |
| cmd_code_i | input | 8 | Command code |
| look_blk_i | input | IDX_W | Block index for the lookup port |
| look_state_o | output | 3 | One-hot state of the looked-up block |
| first_blk_o | output | IDX_W | First-block register |
| last_blk_o | output | IDX_W | Last-block register |
| wp_status_o | output | 3 | Most recently written block state |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle sweep completion strobe |
| cmd_err_o | output | 1 | One-cycle error strobe, issued together with done |

## Verification
The bench builds the block with twelve blocks. Twelve is not a power of two, so the mask 4'b1011 is not contiguous. Written addresses therefore lose bit 2, which exercises the AND masking rather than plain truncation, and lookup indices 12 to 15 fall outside the array. With an array this small, the bench can compare the state of every block, the status register and the exact sweep length against an arithmetic model after each of several hundred commands. Periodic resets keep lock-tight from taking over the array.

// File: rtl/wp_lock_pkg.sv
package wp_lock_pkg;

   localparam logic [2:0] WP_TIGHT    = 3'b001;
   localparam logic [2:0] WP_LOCKED   = 3'b010;
   localparam logic [2:0] WP_UNLOCKED = 3'b100;

   localparam logic [7:0] OP_UNLOCK_RANGE = 8'h23;
   localparam logic [7:0] OP_UNLOCK_ALL   = 8'h27;
   localparam logic [7:0] OP_LOCK_RANGE   = 8'h2A;
   localparam logic [7:0] OP_TIGHT_RANGE  = 8'h2C;

   typedef enum logic [1:0] {
      SW_UNLOCK,
      SW_UNLOCK_ALL,
      SW_LOCK,
      SW_TIGHT
   } sweep_kind_e;

endpackage

// File: rtl/wp_range_regs.sv
module wp_range_regs #(
   parameter int NUM_BLOCKS = 16,
   parameter int DATA_W     = 16,
   localparam int IDX_W     = $clog2(NUM_BLOCKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              first_wr,
   input  logic              last_wr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [IDX_W-1:0]  first_q,
   output logic [IDX_W-1:0]  last_q
);

   logic [IDX_W-1:0] masked;

   generate
      if ((NUM_BLOCKS & (NUM_BLOCKS - 1)) == 0) begin : g_pow2
         logic unused_hi;
         assign unused_hi = ^wr_data[DATA_W-1:IDX_W];
         assign masked    = wr_data[IDX_W-1:0];
      end else begin : g_npow2
         localparam logic [DATA_W-1:0] MASK = DATA_W'(NUM_BLOCKS - 1);
         logic [DATA_W-1:0] anded;
         logic unused_hi;
         assign anded     = wr_data & MASK;
         assign unused_hi = ^anded[DATA_W-1:IDX_W];
         assign masked    = anded[IDX_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= '0;
         last_q  <= '0;
      end else begin
         if (first_wr) first_q <= masked;
         if (last_wr || first_wr) last_q <= masked;
      end
   end

   assert_first_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (first_wr && !last_wr) |=> (first_q == last_q));

   assert_last_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (last_wr && !first_wr) |=> $stable(first_q));

endmodule

// File: rtl/wp_state_array.sv
module wp_state_array
   import wp_lock_pkg::*;
#(
   parameter int NUM_BLOCKS = 16,
   localparam int IDX_W     = $clog2(NUM_BLOCKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W:0]   widx,
   input  logic [2:0]       wstate,
   input  logic [IDX_W:0]   sweep_idx,
   output logic [2:0]       sweep_state,
   input  logic [IDX_W-1:0] look_idx,
   output logic [2:0]       look_state
);

   logic [2:0] st [NUM_BLOCKS];

   for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 st[b] <= WP_LOCKED;
         else if (we && widx == (IDX_W + 1)'(b))     st[b] <= wstate;
      end

      assert_state_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(st[b]) == 1);

      assert_tight_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
         (st[b] == WP_TIGHT) |=> (st[b] == WP_TIGHT));
   end

   always_comb begin
      sweep_state = 3'b000;
      look_state  = 3'b000;
      for (int i = 0; i < NUM_BLOCKS; i++) begin
         if (sweep_idx == (IDX_W + 1)'(i)) sweep_state = st[i];
         if (look_idx == IDX_W'(i))        look_state  = st[i];
      end
   end

endmodule

// File: rtl/wp_sweep_fsm.sv
module wp_sweep_fsm
   import wp_lock_pkg::*;
#(
   parameter int NUM_BLOCKS = 16,
   localparam int IDX_W     = $clog2(NUM_BLOCKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [7:0]       cmd_code,
   input  logic [IDX_W-1:0] first_q,
   input  logic [IDX_W-1:0] last_q,
   input  logic [2:0]       cur_state,
   output logic [IDX_W:0]   idx,
   output logic             we,
   output logic [2:0]       wstate,
   output logic [2:0]       wp_status,
   output logic             busy,
   output logic             done,
   output logic             err
);

   localparam logic [IDX_W:0] LAST_IDX = (IDX_W + 1)'(NUM_BLOCKS - 1);
   localparam logic [IDX_W:0] COUNT    = (IDX_W + 1)'(NUM_BLOCKS);

   sweep_kind_e    kind, kind_n;
   logic           known;
   logic [IDX_W:0] lim;
   logic           in_range, over, stop, write_ok, finish;

   always_comb begin
      known  = 1'b1;
      kind_n = SW_UNLOCK;
      case (cmd_code)
         OP_UNLOCK_RANGE: kind_n = SW_UNLOCK;
         OP_UNLOCK_ALL:   kind_n = SW_UNLOCK_ALL;
         OP_LOCK_RANGE:   kind_n = SW_LOCK;
         OP_TIGHT_RANGE:  kind_n = SW_TIGHT;
         default:         known  = 1'b0;
      endcase
   end

   always_comb begin
      in_range = (idx <= lim);
      over     = (idx >= COUNT);
      stop     = 1'b0;
      write_ok = 1'b1;
      wstate   = WP_UNLOCKED;
      case (kind)
         SW_UNLOCK, SW_UNLOCK_ALL: begin
            stop   = (cur_state == WP_TIGHT);
            wstate = WP_UNLOCKED;
         end
         SW_LOCK: begin
            stop   = (cur_state == WP_TIGHT);
            wstate = WP_LOCKED;
         end
         default: begin
            write_ok = (cur_state != WP_UNLOCKED);
            wstate   = WP_TIGHT;
         end
      endcase
      finish = busy && (!in_range || over || stop);
      we     = busy && !finish && write_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         done      <= 1'b0;
         err       <= 1'b0;
         kind      <= SW_UNLOCK;
         idx       <= '0;
         lim       <= '0;
         wp_status <= WP_LOCKED;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         if (!busy) begin
            if (cmd_valid && known) begin
               busy <= 1'b1;
               kind <= kind_n;
               idx  <= (kind_n == SW_UNLOCK_ALL) ? '0 : {1'b0, first_q};
               lim  <= (kind_n == SW_UNLOCK_ALL) ? LAST_IDX : {1'b0, last_q};
            end
         end else if (finish) begin
            busy <= 1'b0;
            done <= 1'b1;
            err  <= in_range && over;
         end else begin
            idx <= idx + 1'b1;
            if (we) wp_status <= wstate;
         end
      end
   end

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_fall_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_write_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> busy);

   assert_err_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   assert_status_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(wp_status));

   assert_no_write_on_tight_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (we && cur_state == WP_TIGHT) |-> (wstate == WP_TIGHT));

endmodule

// File: rtl/wp_lock_ctrl.sv
module wp_lock_ctrl
   import wp_lock_pkg::*;
#(
   parameter int NUM_BLOCKS = 16,
   parameter int DATA_W     = 16,
   localparam int IDX_W     = $clog2(NUM_BLOCKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              first_wr_i,
   input  logic              last_wr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              cmd_valid_i,
   input  logic [7:0]        cmd_code_i,
   input  logic [IDX_W-1:0]  look_blk_i,
   output logic [2:0]        look_state_o,
   output logic [IDX_W-1:0]  first_blk_o,
   output logic [IDX_W-1:0]  last_blk_o,
   output logic [2:0]        wp_status_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              cmd_err_o
);

   generate
      if (NUM_BLOCKS < 2) begin : g_bad_count
         $error("NUM_BLOCKS must be at least 2");
      end
      if (DATA_W <= IDX_W) begin : g_bad_width
         $error("DATA_W must exceed the block index width");
      end
   endgenerate

   logic [IDX_W:0] sweep_idx;
   logic [2:0]     sweep_state;
   logic           arr_we;
   logic [2:0]     arr_wstate;

   wp_range_regs #(.NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .first_wr (first_wr_i),
      .last_wr  (last_wr_i),
      .wr_data  (wr_data_i),
      .first_q  (first_blk_o),
      .last_q   (last_blk_o)
   );

   wp_sweep_fsm #(.NUM_BLOCKS(NUM_BLOCKS)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid_i),
      .cmd_code  (cmd_code_i),
      .first_q   (first_blk_o),
      .last_q    (last_blk_o),
      .cur_state (sweep_state),
      .idx       (sweep_idx),
      .we        (arr_we),
      .wstate    (arr_wstate),
      .wp_status (wp_status_o),
      .busy      (busy_o),
      .done      (done_o),
      .err       (cmd_err_o)
   );

   wp_state_array #(.NUM_BLOCKS(NUM_BLOCKS)) u_array (
      .clk         (clk),
      .rst_n       (rst_n),
      .we          (arr_we),
      .widx        (sweep_idx),
      .wstate      (arr_wstate),
      .sweep_idx   (sweep_idx),
      .sweep_state (sweep_state),
      .look_idx    (look_blk_i),
      .look_state  (look_state_o)
   );

   assert_busy_on_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && cmd_valid_i && (cmd_code_i == OP_UNLOCK_RANGE || cmd_code_i == OP_UNLOCK_ALL ||
                                  cmd_code_i == OP_LOCK_RANGE || cmd_code_i == OP_TIGHT_RANGE))
      |=> busy_o);

   assert_unknown_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !(cmd_valid_i && (cmd_code_i == OP_UNLOCK_RANGE || cmd_code_i == OP_UNLOCK_ALL ||
                                    cmd_code_i == OP_LOCK_RANGE || cmd_code_i == OP_TIGHT_RANGE)))
      |=> !busy_o);

endmodule

// File: tb/wp_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module wp_lock_ctrl_tb_top;

   localparam int N     = 12;
   localparam int IDX_W = 4;
   localparam int DW    = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            first_wr = 1'b0, last_wr = 1'b0;
   logic [DW-1:0]   wr_data = '0;
   logic            cmd_valid = 1'b0;
   logic [7:0]      cmd_code = '0;
   logic [IDX_W-1:0] look_blk = '0;
   logic [2:0]      look_state, wp_status;
   logic [IDX_W-1:0] first_blk, last_blk;
   logic            busy, done, cmd_err;

   int vectors = 0;
   int fails   = 0;
   int cyc     = 0;

   int mdl [N];
   int mwp, ms, me;

   always #2.5 clk = ~clk;

   wp_lock_ctrl #(.NUM_BLOCKS(N), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .first_wr_i(first_wr), .last_wr_i(last_wr),
      .wr_data_i(wr_data), .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code),
      .look_blk_i(look_blk), .look_state_o(look_state), .first_blk_o(first_blk),
      .last_blk_o(last_blk), .wp_status_o(wp_status), .busy_o(busy),
      .done_o(done), .cmd_err_o(cmd_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      for (int b = 0; b < N; b++) mdl[b] = 2;
      mwp = 2; ms = 0; me = 0;
   endtask

   task automatic check_array(input string req);
      for (int b = 0; b < N; b++) begin
         look_blk = IDX_W'(b);
         #0.5;
         chk(look_state == 3'(mdl[b]), req, look_state, mdl[b]);
      end
      chk(wp_status == 3'(mwp), "R8 status", wp_status, mwp);
   endtask

   task automatic wr_first(input int v);
      @(negedge clk); first_wr = 1'b1; wr_data = DW'(v);
      @(negedge clk); first_wr = 1'b0;
      ms = v & (N - 1); me = ms;
      chk(first_blk == 4'(ms), "R3 first", first_blk, ms);
      chk(last_blk == 4'(me), "R3 copy", last_blk, me);
   endtask

   task automatic wr_last(input int v);
      @(negedge clk); last_wr = 1'b1; wr_data = DW'(v);
      @(negedge clk); last_wr = 1'b0;
      me = v & (N - 1);
      chk(last_blk == 4'(me), "R3 last", last_blk, me);
      chk(first_blk == 4'(ms), "R3 first kept", first_blk, ms);
   endtask

   task automatic model(input logic [7:0] code, output int steps, output bit eerr);
      int lo, hi;
      steps = 0; eerr = 0;
      lo = (code == 8'h27) ? 0 : ms;
      hi = (code == 8'h27) ? N - 1 : me;
      for (int b = lo; b <= hi; b++) begin
         if (b >= N) begin eerr = 1; break; end
         if (code == 8'h2C) begin
            if (mdl[b] != 4) begin mdl[b] = 1; mwp = 1; end
         end else begin
            if (mdl[b] == 1) break;
            mdl[b] = (code == 8'h2A) ? 2 : 4;
            mwp = mdl[b];
         end
         steps++;
      end
      steps++;
   endtask

   task automatic run_cmd(input logic [7:0] code, input string req, input bit inject);
      int steps, n;
      bit eerr;
      model(code, steps, eerr);
      @(negedge clk); cmd_valid = 1'b1; cmd_code = code;
      @(negedge clk); cmd_valid = 1'b0;
      n = 0;
      while (busy && n < 100) begin
         n++;
         if (inject && n == 1) begin cmd_valid = 1'b1; cmd_code = 8'h2A; end
         @(negedge clk);
         cmd_valid = 1'b0;
      end
      chk(n == steps, {req, " R9 busy length"}, n, steps);
      chk(done == 1'b1, {req, " R9 done"}, done, 1);
      chk(cmd_err == eerr, {req, " R11 err"}, cmd_err, eerr);
      @(negedge clk);
      chk(done == 1'b0, {req, " R9 done single"}, done, 0);
      check_array(req);
   endtask

   initial begin
      int a, c, op;
      logic [7:0] ops [4];
      ops[0] = 8'h23; ops[1] = 8'h2A; ops[2] = 8'h2C; ops[3] = 8'h27;

      do_reset();
      // R1 reset state
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(first_blk == 4'd0 && last_blk == 4'd0, "R1 regs", first_blk, 0);
      check_array("R1 reset");
      // R2 out-of-range lookup
      for (int b = N; b < 16; b++) begin
         look_blk = IDX_W'(b); #0.5;
         chk(look_state == 3'b000, "R2 out of range", look_state, 0);
      end

      // R3 masking (mask 4'b1011)
      wr_first(13);
      wr_last(14);
      run_cmd(8'h23, "R4 unlock", 1'b0);
      // R7 tight skips unlocked: range 8..11
      wr_first(8); wr_last(11);
      run_cmd(8'h2C, "R7 tight", 1'b0);
      // R6 unlock all stops at block 8 (tight)
      run_cmd(8'h27, "R6 unlock all", 1'b0);
      // R5 lock range 0..10 stops at 8
      wr_first(0); wr_last(10);
      run_cmd(8'h2A, "R5 lock", 1'b0);
      // R12 tight survives unlock from the tight block
      wr_first(8);
      run_cmd(8'h23, "R12 tight sticky", 1'b0);
      // R9 empty range
      wr_first(3); wr_last(1);
      run_cmd(8'h2A, "R9 empty range", 1'b0);
      // R10 command during busy ignored
      wr_first(0); wr_last(3);
      run_cmd(8'h23, "R10 busy ignore", 1'b1);
      // R10 unknown code ignored
      @(negedge clk); cmd_valid = 1'b1; cmd_code = 8'h55;
      @(negedge clk); cmd_valid = 1'b0;
      chk(busy == 1'b0, "R10 unknown busy", busy, 0);
      chk(done == 1'b0, "R10 unknown done", done, 0);
      check_array("R10 unknown");

      // sweep of arithmetic patterns
      for (int it = 0; it < 300; it++) begin
         if (it % 12 == 0) do_reset();
         a  = (it * 7 + 3) % 16;
         c  = (it * 11 + 5) % 16;
         op = (it * 5 + it / 4) % 4;
         wr_first(a);
         if (it % 3 != 0) wr_last(c);
         run_cmd(ops[op], (op == 0) ? "R4 sweep" : (op == 1) ? "R5 sweep" :
                          (op == 2) ? "R7 sweep" : "R6 sweep", it % 5 == 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule